// File: doc/BRIEF.md
# Low-Speed Oscillator Enable and Ready Controller

This block controls a low-speed internal RC oscillator that feeds the watchdog and wakeup logic. Software sets or clears one enable bit, and the block drives that bit to the oscillator's enable pin. The oscillator returns a raw "stable" level that is not aligned to any clock. The block passes this level through two synchronizer flops. It then counts a programmable number of consecutive stable cycles and only after that sets a ready flag. Software has no write path to the ready flag.

The low-speed clock output is gated off until ready is set. It is also cut in the same cycle that the enable register clears. When ready first rises, a sticky interrupt flag is set. The flag is cleared by writing 1 to a separate clear strobe, and the interrupt line is raised only while its enable bit is set. Stop and standby states leave the oscillator and its gate exactly as they are.

Top module: `lsosc_ctrl`

## Requirements
- R1: While reset is held, and on leaving it, osc_en_o, ready_o, lsclk_o, irq_flag_o and irq_o are all 0.
- R2: A cycle with en_wr_i=1 loads en_wdata_i into the enable register, which osc_en_o shows from the next clock edge.
- R3: With stable_i already high and synchronized, ready_o rises settle_cnt_i+2 clock edges after the edge that samples the enable write. With the oscillator enabled and stable_i rising, ready_o rises settle_cnt_i+3 edges after the first edge that samples stable_i high.
- R4: ready_o never rises while the synchronized stable level is low. If stable drops before the count completes, the count restarts from zero.
- R5: lsclk_o equals osc_clk_i while both the enable register and ready are 1, and is 0 otherwise. It drops in the same cycle that osc_en_o falls.
- R6: ready_o clears no later than the second clock edge after the edge that clears the enable register.
- R7: Re-enabling after a disable restarts the stability count from zero, so the latency of R3 applies again in full.
- R8: irq_flag_o is set on the edge where ready_o rises and stays set until a cycle with irq_clr_i=1. When set and clear coincide, set wins.
- R9: irq_o is 1 exactly when irq_flag_o=1 and the interrupt enable loaded through ie_wr_i/ie_wdata_i is 1.
- R10: lp_mode_i (stop or standby) has no effect on osc_en_o, ready_o or lsclk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_wr_i | input | 1 | Write strobe for the oscillator enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| ie_wr_i | input | 1 | Write strobe for the interrupt enable bit |
| ie_wdata_i | input | 1 | Value written to the interrupt enable bit |
| irq_clr_i | input | 1 | Write-1 clear of the interrupt flag |
| settle_cnt_i | input | 8 | Stable cycles required before ready |
| lp_mode_i | input | 1 | Stop/standby indication |
| stable_i | input | 1 | Raw oscillator stability level, asynchronous |
| osc_clk_i | input | 1 | Raw low-speed oscillator clock |
| osc_en_o | output | 1 | Enable to the oscillator |
| ready_o | output | 1 | Hardware ready flag |
| lsclk_o | output | 1 | Gated low-speed clock |
| irq_flag_o | output | 1 | Sticky ready interrupt flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Random settle counts with stable already high test the enable-to-ready latency. Random counts with stable_i rising after enable separate the synchronizer delay from the count itself. A stable pulse shorter than the count, and a disable part-way through counting, show whether the counter restarts or carries on from old progress. Directed disables, a clear held through the ready edge, and toggling of the low-power input test the gate's immediate cut-off, set-over-clear priority, and that low power leaves everything unchanged.

// File: rtl/lsosc_pkg.sv
package lsosc_pkg;
  localparam int LSOSC_CNT_W = 8;
  typedef logic [LSOSC_CNT_W-1:0] settle_t;
endpackage

// File: rtl/lsosc_rst_sync.sv
module lsosc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/lsosc_sync.sv
module lsosc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/lsosc_settle.sv
module lsosc_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             stable_s_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             ready_o,
  output logic             ready_rise_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ready_q, ready_d;
  logic             cnt_done;
  logic             cnt_ce;

  assign cnt_done = (cnt_q == settle_i);
  assign cnt_ce   = !en_i || !stable_s_i || !cnt_done;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || !stable_s_i) cnt_d = '0;
    else if (!cnt_done)       cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (!en_i)        ready_d = 1'b0;
    else if (ready_q) ready_d = 1'b1;
    else              ready_d = stable_s_i && cnt_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign ready_o      = ready_q;
  assign ready_rise_o = ready_d && !ready_q;

  // R4: ready only rises out of a stable, enabled state
  p_ready_needs_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && ready_d) |-> (stable_s_i && en_i));
  // R6: a cleared enable drops ready at the next edge
  p_ready_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !ready_q);
  // R7: a disable leaves the counter at zero
  p_count_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/lsosc_irq.sv
module lsosc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_wr_i,
  input  logic ie_wdata_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d;
  logic ie_q;

  always_comb begin
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie_q <= 1'b0;
    else if (ie_wr_i) ie_q <= ie_wdata_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_q;

  // R8: flag holds without a clear
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R8: set wins over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/lsosc_ctrl.sv
module lsosc_ctrl
  import lsosc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_wr_i,
  input  logic    en_wdata_i,
  input  logic    ie_wr_i,
  input  logic    ie_wdata_i,
  input  logic    irq_clr_i,
  input  settle_t settle_cnt_i,
  input  logic    lp_mode_i,
  input  logic    stable_i,
  input  logic    osc_clk_i,
  output logic    osc_en_o,
  output logic    ready_o,
  output logic    lsclk_o,
  output logic    irq_flag_o,
  output logic    irq_o
);
  localparam int SYNC_STAGES = 2;

  logic rst_s_n;
  logic en_q, en_d;
  logic stable_s;
  logic ready;
  logic ready_rise;
  logic gate;
  logic lp_unused;

  assign lp_unused = lp_mode_i;

  lsosc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  lsosc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .async_i(stable_i), .sync_o(stable_s));

  always_comb begin
    en_d = en_wr_i ? en_wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) en_q <= 1'b0;
    else          en_q <= en_d;
  end

  lsosc_settle #(.CNT_W(LSOSC_CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_s_n), .en_i(en_q), .stable_s_i(stable_s),
    .settle_i(settle_cnt_i), .ready_o(ready), .ready_rise_o(ready_rise));

  lsosc_irq u_irq (
    .clk(clk), .rst_n(rst_s_n), .set_i(ready_rise), .clr_i(irq_clr_i),
    .ie_wr_i(ie_wr_i), .ie_wdata_i(ie_wdata_i),
    .flag_o(irq_flag_o), .irq_o(irq_o));

  assign gate       = en_q && ready;
  assign osc_en_o   = en_q;
  assign ready_o    = ready;
  assign lsclk_o    = osc_clk_i && gate;

  // R2: enable register follows the write
  p_en_follow_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    en_wr_i |=> (osc_en_o == $past(en_wdata_i)));
  // R5: no clock out while disabled or not ready
  p_gate_closed_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!osc_en_o || !ready_o) |-> !lsclk_o);
  // R9: interrupt line implies a pending flag
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_o |-> irq_flag_o);
  // R10: low power alone never drops the enable
  p_lp_keeps_en_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (osc_en_o && !en_wr_i && lp_mode_i) |=> osc_en_o);
endmodule

// File: tb/lsosc_ctrl_test.sv
module lsosc_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 0, en_wdata = 0, ie_wr = 0, ie_wdata = 0, irq_clr = 0;
  logic [7:0] settle = 8'd0;
  logic lp = 0, stable = 0, osc_clk = 1;
  logic osc_en, ready, lsclk, irq_flag, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsosc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .ie_wr_i(ie_wr), .ie_wdata_i(ie_wdata), .irq_clr_i(irq_clr),
    .settle_cnt_i(settle), .lp_mode_i(lp), .stable_i(stable),
    .osc_clk_i(osc_clk), .osc_en_o(osc_en), .ready_o(ready),
    .lsclk_o(lsclk), .irq_flag_o(irq_flag), .irq_o(irq));

  function automatic int lat_from_enable(int s); return s + 2; endfunction
  function automatic int lat_from_stable(int s); return s + 3; endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_en(bit v);
    @(negedge clk); en_wr = 1; en_wdata = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic enable_measure(output int n);
    @(negedge clk); en_wr = 1; en_wdata = 1;
    n = 0;
    @(negedge clk); en_wr = 0; n = 1;
    while (!ready && n < 400) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 osc_en", osc_en, 0); check("R1 ready", ready, 0);
    check("R1 lsclk", lsclk, 0);   check("R1 flag", irq_flag, 0);
    check("R1 irq", irq, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release", {osc_en, ready, irq_flag}, 0);

    // R4: enabled but not stable never reaches ready
    settle = 8'd10;
    write_en(1);
    check("R2 enable loads", osc_en, 1);
    repeat (40) @(negedge clk);
    check("R4 no ready while unstable", ready, 0);
    stable = 1; repeat (5) @(negedge clk); stable = 0;
    repeat (30) @(negedge clk);
    check("R4 short stable pulse", ready, 0);
    stable = 1; n = 0;
    while (!ready && n < 400) begin @(negedge clk); n++; end
    check("R4 count restarted after drop", n, lat_from_stable(10));
    check("R8 flag on ready", irq_flag, 1);
    check("R9 irq masked", irq, 0);
    @(negedge clk); ie_wr = 1; ie_wdata = 1;
    @(negedge clk); ie_wr = 0;
    check("R9 irq unmasked", irq, 1);
    // R5 gate follows osc clock
    osc_clk = 0; #1 check("R5 lsclk low phase", lsclk, 0);
    osc_clk = 1; #1 check("R5 lsclk high phase", lsclk, 1);
    // R10 low power no effect
    lp = 1; repeat (6) @(negedge clk);
    check("R10 lp en/ready/clk", {osc_en, ready, lsclk}, 3'b111);
    lp = 0;
    // R8 sticky then clear
    repeat (4) @(negedge clk);
    check("R8 sticky", irq_flag, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check("R8 cleared", irq_flag, 0);
    check("R9 irq follows flag", irq, 0);
    // R5/R6 disable
    @(negedge clk); en_wr = 1; en_wdata = 0;
    @(negedge clk); en_wr = 0;
    check("R5 gate cut with enable", lsclk, 0);
    check("R2 disable loads", osc_en, 0);
    @(negedge clk);
    check("R6 ready cleared", ready, 0);

    // R7: partial count then disable and re-enable
    settle = 8'd20;
    write_en(1); repeat (10) @(negedge clk);
    write_en(0);
    enable_measure(n);
    check("R7 restart full latency", n, lat_from_enable(20));
    write_en(0); @(negedge clk);

    // R8 set wins over held clear
    settle = 8'd3; irq_clr = 1;
    enable_measure(n);
    check("R8 set wins", irq_flag, 1);
    @(negedge clk);
    check("R8 clear after set", irq_flag, 0);
    irq_clr = 0;
    write_en(0); @(negedge clk);

    // Random settle counts, both start orders
    for (int i = 0; i < 24; i++) begin
      int s;
      s = $urandom_range(0, 40);
      settle = s[7:0];
      lp = $urandom_range(0, 1);
      if (i % 2 == 0) begin
        stable = 1; repeat (3) @(negedge clk);
        enable_measure(n);
        check("R3 latency from enable", n, lat_from_enable(s));
      end else begin
        stable = 0; write_en(1); repeat ($urandom_range(0, 5)) @(negedge clk);
        stable = 1; n = 0;
        while (!ready && n < 400) begin @(negedge clk); n++; end
        check("R3 latency from stable", n, lat_from_stable(s));
      end
      check("R5 gate open when ready", lsclk, 1);
      write_en(0); @(negedge clk);
      check("R6 ready off", ready, 0);
      irq_clr = 1; @(negedge clk); irq_clr = 0;
    end
    lp = 0;
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule